// File: doc/BRIEF.md
# Indirect register command bridge for a two-wire bus controller

The bridge gives a host one 64-bit command word through which it reaches a small bank of 8-bit registers inside a two-wire bus controller. The host writes the word with its top bit set to request an access. The word names a register by a 3-bit index, gives the direction and, for a write, carries the byte to store. The bridge performs that single access and then clears the top bit. The host learns that the access is over by reading the word back. After a read access the low byte of the word holds the register value.

The register bank is made of five registers: the own bus address, the data byte, the control byte, the clock divider byte and the extended own address. It feeds these to the serial engine as plain outputs. The status byte comes in from the engine and can only be read. A write to the reset index sends a one-cycle reset pulse to the engine and clears the bank. The serial engine and any bus fabric are outside this block. The host port is a single write strobe with a 64-bit word, and the stored word is always visible on an output.

Top module: `twi_cmd_bridge`

## Requirements
- R1: After reset the command word is all zeros, every bank output is 0x00 and the reset pulse is low.
- R2: Command word layout: bit 63 valid, bits 60:57 operation, bit 56 direction (1 read, 0 write), bits 34:32 register index, bits 31:0 data. A host write with valid=1, operation 6 and direction 0 updates the indexed register at the next clock edge. The valid bit stays 1 through that edge and reads 0 after the edge that follows.
- R3: A host write with valid=1, operation 6 and direction 1 completes at the next clock edge. At that edge valid goes to 0, bits 7:0 take the register value and bits 31:8 become zero.
- R4: Register indices are 0 own address, 1 data, 2 control, 3 clock divider, 4 extended own address and 7 reset. Index 3 stores the clock divider on a write. On a read, index 3 returns the status input instead of the divider.
- R5: A host write that arrives while the valid bit is 1 is ignored. The word and the registers behave as if it had not happened.
- R6: A host write with valid=1 and an operation other than 6 is stored with valid already 0. No register changes.
- R7: A write to index 7 clears all five bank registers. It drives the reset pulse high for exactly the one cycle that follows the edge where the clear happens.
- R8: Writes to indices 5 and 6 change nothing, and reads of indices 5, 6 and 7 return 0x00.
- R9: An access leaves bits 62:32 of the word unchanged.
- R10: A host write with valid=0 is stored as written and starts no access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| host_we_i | input | 1 | Host write strobe for the command word |
| host_wdata_i | input | 64 | Command word written by the host |
| stat_i | input | 8 | Status byte from the serial engine |
| cmd_word_o | output | 64 | Current command word, read back by the host |
| own_addr_o | output | 8 | Own bus address register |
| data_o | output | 8 | Data byte register |
| ctl_o | output | 8 | Control register |
| clk_div_o | output | 8 | Clock divider register |
| ext_addr_o | output | 8 | Extended own address register |
| soft_rst_o | output | 1 | One-cycle reset pulse to the serial engine |

## Verification
Call the edge that captures a host write k. A read result and its valid clear are due at edge k+1. A register write lands at edge k+1, and its valid clear follows at edge k+2. The reset pulse is high between edges k+1 and k+2. A rejected operation shows valid low right after edge k. The bench drives on falling edges and counts falling edges until valid drops. It requires exactly two for a write and one for a read. It samples register outputs and the pulse at the falling edge after the edge where each change is due, so every check lands on a known cycle.

// File: rtl/twi_cmd_pkg.sv
package twi_cmd_pkg;
  localparam int CMD_W   = 64;
  localparam int V_BIT   = 63;
  localparam int R_BIT   = 56;
  localparam int OP_LSB  = 57;
  localparam int OP_W    = 4;
  localparam int IDX_LSB = 32;
  localparam int IDX_W   = 3;
  localparam int DATA_W  = 32;
  localparam int REG_W   = 8;
  localparam int STORE_N = 5;
  localparam logic [OP_W-1:0] OP_REG = 4'd6;

  typedef enum logic [IDX_W-1:0] {
    IDX_OWN   = 3'd0,
    IDX_DATA  = 3'd1,
    IDX_CTL   = 3'd2,
    IDX_CLK   = 3'd3,
    IDX_EXT   = 3'd4,
    IDX_RSV5  = 3'd5,
    IDX_RSV6  = 3'd6,
    IDX_RESET = 3'd7
  } reg_idx_e;
endpackage

// File: rtl/twi_cmd_word_reg.sv
module twi_cmd_word_reg
  import twi_cmd_pkg::*;
#(
  parameter int W = CMD_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             host_we_i,
  input  logic [W-1:0]     host_wdata_i,
  input  logic             done_wr_i,
  input  logic             done_rd_i,
  input  logic [REG_W-1:0] rd_byte_i,
  output logic [W-1:0]     word_o
);
  logic [W-1:0] word_q, word_d;

  always_comb begin
    word_d = word_q;
    if (word_q[V_BIT]) begin
      if (done_rd_i) begin
        word_d[V_BIT]        = 1'b0;
        word_d[DATA_W-1:0]   = {{(DATA_W-REG_W){1'b0}}, rd_byte_i};
      end else if (done_wr_i) begin
        word_d[V_BIT]        = 1'b0;
      end
    end else if (host_we_i) begin
      word_d = host_wdata_i;
      // only the register-access op starts work
      if (host_wdata_i[OP_LSB+OP_W-1:OP_LSB] != OP_REG) word_d[V_BIT] = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) word_q <= '0;
    else         word_q <= word_d;
  end

  assign word_o = word_q;
endmodule

// File: rtl/twi_access_seq.sv
module twi_access_seq
  import twi_cmd_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            valid_i,
  input  logic            rd_i,
  input  logic [OP_W-1:0] op_i,
  output logic            wr_stb_o,
  output logic            done_wr_o,
  output logic            done_rd_o
);
  logic phase_q;
  logic active;

  assign active    = valid_i && (op_i == OP_REG);
  assign done_rd_o = active && rd_i && !phase_q;
  assign wr_stb_o  = active && !rd_i && !phase_q;
  assign done_wr_o = active && phase_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        phase_q <= 1'b0;
    else if (wr_stb_o)  phase_q <= 1'b1;
    else if (done_wr_o) phase_q <= 1'b0;
  end
endmodule

// File: rtl/twi_reg_bank.sv
module twi_reg_bank
  import twi_cmd_pkg::*;
#(
  parameter int N = STORE_N,
  parameter int RW = REG_W
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  wr_stb_i,
  input  logic [IDX_W-1:0]      idx_i,
  input  logic [RW-1:0]         wbyte_i,
  input  logic [RW-1:0]         stat_i,
  output logic [N-1:0][RW-1:0]  regs_o,
  output logic [RW-1:0]         rd_byte_o,
  output logic                  soft_rst_o
);
  logic clr;
  logic [N-1:0][RW-1:0] regs_q;

  assign clr = wr_stb_i && (idx_i == IDX_RESET);

  for (genvar g = 0; g < N; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                  regs_q[g] <= '0;
      else if (clr)                                 regs_q[g] <= '0;
      else if (wr_stb_i && idx_i == IDX_W'(g))      regs_q[g] <= wbyte_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) soft_rst_o <= 1'b0;
    else         soft_rst_o <= clr;
  end

  always_comb begin
    unique case (idx_i)
      IDX_OWN:  rd_byte_o = regs_q[0];
      IDX_DATA: rd_byte_o = regs_q[1];
      IDX_CTL:  rd_byte_o = regs_q[2];
      IDX_CLK:  rd_byte_o = stat_i;   // read side of index 3 is status
      IDX_EXT:  rd_byte_o = regs_q[4];
      default:  rd_byte_o = '0;
    endcase
  end

  assign regs_o = regs_q;
endmodule

// File: rtl/twi_cmd_bridge.sv
module twi_cmd_bridge
  import twi_cmd_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              host_we_i,
  input  logic [CMD_W-1:0]  host_wdata_i,
  input  logic [REG_W-1:0]  stat_i,
  output logic [CMD_W-1:0]  cmd_word_o,
  output logic [REG_W-1:0]  own_addr_o,
  output logic [REG_W-1:0]  data_o,
  output logic [REG_W-1:0]  ctl_o,
  output logic [REG_W-1:0]  clk_div_o,
  output logic [REG_W-1:0]  ext_addr_o,
  output logic              soft_rst_o
);
  logic                         wr_stb, done_wr, done_rd;
  logic [REG_W-1:0]             rd_byte;
  logic [STORE_N-1:0][REG_W-1:0] regs;

  twi_cmd_word_reg #(.W(CMD_W)) u_word (
    .clk_i, .rst_ni, .host_we_i, .host_wdata_i,
    .done_wr_i(done_wr), .done_rd_i(done_rd), .rd_byte_i(rd_byte),
    .word_o(cmd_word_o)
  );

  twi_access_seq u_seq (
    .clk_i, .rst_ni,
    .valid_i(cmd_word_o[V_BIT]),
    .rd_i(cmd_word_o[R_BIT]),
    .op_i(cmd_word_o[OP_LSB+OP_W-1:OP_LSB]),
    .wr_stb_o(wr_stb), .done_wr_o(done_wr), .done_rd_o(done_rd)
  );

  twi_reg_bank #(.N(STORE_N), .RW(REG_W)) u_bank (
    .clk_i, .rst_ni,
    .wr_stb_i(wr_stb),
    .idx_i(cmd_word_o[IDX_LSB+IDX_W-1:IDX_LSB]),
    .wbyte_i(cmd_word_o[REG_W-1:0]),
    .stat_i,
    .regs_o(regs), .rd_byte_o(rd_byte), .soft_rst_o
  );

  assign own_addr_o = regs[0];
  assign data_o     = regs[1];
  assign ctl_o      = regs[2];
  assign clk_div_o  = regs[3];
  assign ext_addr_o = regs[4];
endmodule

// File: rtl/twi_cmd_bridge_chk.sv
module twi_cmd_bridge_chk
  import twi_cmd_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              host_we_i,
  input logic [CMD_W-1:0]  host_wdata_i,
  input logic [REG_W-1:0]  stat_i,
  input logic [CMD_W-1:0]  cmd_word_o,
  input logic [REG_W-1:0]  own_addr_o,
  input logic [REG_W-1:0]  data_o,
  input logic [REG_W-1:0]  ctl_o,
  input logic [REG_W-1:0]  clk_div_o,
  input logic [REG_W-1:0]  ext_addr_o,
  input logic              soft_rst_o
);
  logic start_reg, start_wr, start_rd;
  assign start_reg = host_we_i && !cmd_word_o[V_BIT] && host_wdata_i[V_BIT] &&
                     host_wdata_i[OP_LSB+OP_W-1:OP_LSB] == OP_REG;
  assign start_wr  = start_reg && !host_wdata_i[R_BIT];
  assign start_rd  = start_reg &&  host_wdata_i[R_BIT];

  assert_wr_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_wr |=> ##1 cmd_word_o[V_BIT]);
  assert_wr_clear_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_wr |=> ##2 !cmd_word_o[V_BIT]);
  assert_rd_clear_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_rd |=> ##1 !cmd_word_o[V_BIT]);
  assert_busy_ignore_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (host_we_i && cmd_word_o[V_BIT]) |=> cmd_word_o[62:32] == $past(cmd_word_o[62:32]));
  assert_bad_op_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (host_we_i && !cmd_word_o[V_BIT] &&
     host_wdata_i[OP_LSB+OP_W-1:OP_LSB] != OP_REG) |=> !cmd_word_o[V_BIT]);
  assert_pulse_one_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst_o |=> !soft_rst_o);
  assert_pulse_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst_o |-> (own_addr_o == 0 && data_o == 0 && ctl_o == 0 &&
                    clk_div_o == 0 && ext_addr_o == 0));
  assert_hi_fields_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_word_o[V_BIT] |=> cmd_word_o[62:32] == $past(cmd_word_o[62:32]));
endmodule

bind twi_cmd_bridge twi_cmd_bridge_chk u_chk (.*);

// File: tb/tb_twi_cmd_bridge.sv
module tb_twi_cmd_bridge;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        host_we_i = 1'b0;
  logic [63:0] host_wdata_i = '0;
  logic [7:0]  stat_i = 8'h00;
  logic [63:0] cmd_word_o;
  logic [7:0]  own_addr_o, data_o, ctl_o, clk_div_o, ext_addr_o;
  logic        soft_rst_o;

  int n_chk = 0;
  int n_fail = 0;
  logic [7:0] mdl [0:4];

  always #5 clk_i = ~clk_i;

  twi_cmd_bridge dut (.*);

  localparam logic [10:0] VEC [0:7] = '{
    {3'd0, 8'h5A}, {3'd1, 8'hC3}, {3'd2, 8'h44}, {3'd3, 8'h2F},
    {3'd4, 8'h81}, {3'd5, 8'hFF}, {3'd6, 8'hEE}, {3'd1, 8'h00}
  };

  function automatic logic [63:0] mk(logic v, logic r, logic [3:0] op,
                                     logic [2:0] idx, logic [31:0] d,
                                     logic [22:0] oth);
    logic [63:0] w;
    w = '0;
    w[63] = v; w[62:61] = oth[22:21]; w[60:57] = op; w[56] = r;
    w[55:35] = oth[20:0]; w[34:32] = idx; w[31:0] = d;
    return w;
  endfunction

  task automatic chk(input logic ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic [63:0] w);
    @(negedge clk_i); host_we_i = 1'b1; host_wdata_i = w;
    @(negedge clk_i); host_we_i = 1'b0;
  endtask

  task automatic wait_done(output int n);
    n = 0;
    while (cmd_word_o[63] && n < 10) begin @(negedge clk_i); n++; end
  endtask

  function automatic logic [7:0] port_val(input int i);
    case (i)
      0: return own_addr_o; 1: return data_o; 2: return ctl_o;
      3: return clk_div_o;  default: return ext_addr_o;
    endcase
  endfunction

  task automatic chk_bank(input string tag);
    for (int i = 0; i < 5; i++) chk(port_val(i) == mdl[i], tag, 64'(port_val(i)), 64'(mdl[i]));
  endtask

  initial begin
    #2000000;
    n_fail++; n_chk++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int n;
    logic [63:0] w, prev;
    for (int i = 0; i < 5; i++) mdl[i] = 8'h00;
    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk(cmd_word_o == 64'h0, "R1 word", cmd_word_o, 0);
    chk(soft_rst_o == 1'b0, "R1 pulse", 64'(soft_rst_o), 0);
    chk_bank("R1 bank");
    rst_ni = 1'b1;
    stat_i = 8'hA7;

    // table: write then read back each index (R2 R3 R4 R8)
    for (int v = 0; v < 8; v++) begin
      int ix;
      logic [7:0] d, e;
      ix = int'(VEC[v][10:8]); d = VEC[v][7:0];
      issue(mk(1'b1, 1'b0, 4'd6, 3'(ix), {24'h123456, d}, 23'h0));
      wait_done(n);
      chk(n == 2, "R2 write latency", 64'(n), 2);
      if (ix < 5) mdl[ix] = d;
      chk_bank(ix < 5 ? "R2 R4 bank" : "R8 ignored write");
      issue(mk(1'b1, 1'b1, 4'd6, 3'(ix), 32'hFFFF_FF00, 23'h0));
      wait_done(n);
      chk(n == 1, "R3 read latency", 64'(n), 1);
      e = (ix == 3) ? stat_i : (ix < 5 ? mdl[ix] : 8'h00);
      chk(cmd_word_o[31:0] == {24'h0, e}, ix == 3 ? "R4 status read" :
          (ix < 5 ? "R3 read data" : "R8 reserved read"), 64'(cmd_word_o[31:0]), 64'(e));
    end

    // R2 register updated while valid still 1
    issue(mk(1'b1, 1'b0, 4'd6, 3'd2, 32'h0000_0099, 23'h0));
    @(negedge clk_i);
    chk(ctl_o == 8'h99 && cmd_word_o[63], "R2 update with valid held",
        {cmd_word_o[63], 55'h0, ctl_o}, {1'b1, 55'h0, 8'h99});
    @(negedge clk_i);
    chk(!cmd_word_o[63], "R2 valid cleared", 64'(cmd_word_o[63]), 0);
    mdl[2] = 8'h99;

    // R4 status tracks input
    stat_i = 8'h3C;
    issue(mk(1'b1, 1'b1, 4'd6, 3'd3, 32'h0, 23'h0));
    wait_done(n);
    chk(cmd_word_o[7:0] == 8'h3C, "R4 status", 64'(cmd_word_o[7:0]), 64'h3C);
    chk(clk_div_o == mdl[3], "R4 divider kept", 64'(clk_div_o), 64'(mdl[3]));

    // R9 high fields preserved on read
    w = mk(1'b1, 1'b1, 4'd6, 3'd0, 32'h0, 23'h5A5A5A);
    issue(w);
    wait_done(n);
    chk(cmd_word_o[62:32] == w[62:32], "R9 fields kept", 64'(cmd_word_o[62:32]), 64'(w[62:32]));

    // R5 write while busy ignored
    @(negedge clk_i); host_we_i = 1'b1;
    host_wdata_i = mk(1'b1, 1'b0, 4'd6, 3'd4, 32'h11, 23'h0);
    @(negedge clk_i); host_wdata_i = mk(1'b1, 1'b0, 4'd6, 3'd0, 32'h22, 23'h0);
    @(negedge clk_i); host_we_i = 1'b0;
    wait_done(n);
    mdl[4] = 8'h11;
    chk(cmd_word_o[34:32] == 3'd4, "R5 word kept", 64'(cmd_word_o[34:32]), 4);
    chk_bank("R5 bank");

    // R6 other operation code
    w = mk(1'b1, 1'b0, 4'd3, 3'd1, 32'h77, 23'h0);
    issue(w);
    chk(cmd_word_o == {1'b0, w[62:0]}, "R6 valid clear", cmd_word_o, {1'b0, w[62:0]});
    @(negedge clk_i);
    chk_bank("R6 bank");

    // R10 write with valid low
    w = mk(1'b0, 1'b0, 4'd6, 3'd1, 32'hABCD_0055, 23'h1);
    issue(w);
    chk(cmd_word_o == w, "R10 verbatim", cmd_word_o, w);
    @(negedge clk_i);
    chk_bank("R10 bank");

    // R7 soft reset
    prev = cmd_word_o;
    issue(mk(1'b1, 1'b0, 4'd6, 3'd7, 32'h0, 23'h0));
    chk(soft_rst_o == 1'b0, "R7 pulse early", 64'(soft_rst_o), 0);
    @(negedge clk_i);
    chk(soft_rst_o == 1'b1, "R7 pulse high", 64'(soft_rst_o), 1);
    for (int i = 0; i < 5; i++) mdl[i] = 8'h00;
    chk_bank("R7 clear");
    @(negedge clk_i);
    chk(soft_rst_o == 1'b0, "R7 pulse end", 64'(soft_rst_o), 0);
    issue(mk(1'b1, 1'b1, 4'd6, 3'd7, 32'h0, 23'h0));
    wait_done(n);
    chk(cmd_word_o[7:0] == 8'h00, "R8 reset index read", 64'(cmd_word_o[7:0]), 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule